// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns a parallel word into a serial bit stream. A low level on the load input copies the parallel inputs into the register at once, with no clock needed. Once the load is released, each rising edge of the effective clock moves the contents one place toward the last stage. The serial input fills stage 0, and the last stage appears on a true output and on an inverted output.

The effective clock is the OR of the clock pin and the active-low enable pin. Holding the enable high therefore freezes the register. With the clock pin parked low, the enable pin can act as the clock itself. The register is built from byte-wide slices. The `NUM_BYTES` parameter sets how many slices are chained, and the last stage of each slice feeds the serial input of the next. Several blocks can be chained in the same way: the serial output of one block drives the serial input of the next.

Top module: `plsoShiftReg`

## Requirements
- R1: While `loadN` is 0, every stage equals the matching `parIn` bit and follows changes on `parIn` without any clock, so `serOut` equals `parIn[W-1]` (W = 8*NUM_BYTES).
- R2: With `loadN` = 1 and `clkEnN` = 0, each rising `clk` edge moves stage i into stage i+1 and `serIn` into stage 0. After a load, the stream on `serOut` is `parIn[W-1]`, then `parIn[W-2]`, and so on down to `parIn[0]`.
- R3: With `clk` held at 0, a rising edge on `clkEnN` shifts exactly as a rising `clk` edge does.
- R4: While `clkEnN` = 1, the contents do not change, whatever `clk` and `serIn` do.
- R5: `serOutN` is always the inverse of `serOut`.
- R6: The slices form one chain of W stages. A bit presented on `serIn` reaches `serOut` after exactly W shifts.
- R7: Clock edges while `loadN` = 0 have no effect. After the release, the register holds exactly the last `parIn` value.
- R8: When `loadN` rises while `clk` or `clkEnN` is 1, no shift takes place, and `serOut` stays at `parIn[W-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, ORed with `clkEnN` |
| clkEnN | input | 1 | Active-low clock enable, interchangeable with `clk` |
| loadN | input | 1 | Active-low asynchronous parallel load |
| parIn | input | W | Parallel data; bit W-1 loads the last stage |
| serIn | input | 1 | Serial data into stage 0 |
| serOut | output | 1 | Last stage |
| serOutN | output | 1 | Inverse of the last stage |

## Verification
Loads are tried with all-zero words, single-bit words at either end, and alternating words. These patterns expose a reversed bit order or a swapped set/clear path. Changing `parIn` while the load is held low shows whether the load follows the level or latches a single value. Shift runs of more than W bits show whether the serial input crosses every slice boundary. A hold phase with `serIn` toggling, followed by a full readout, catches any stray shift. A final run clocked only by the enable pin confirms that the two clock pins are interchangeable.

// File: rtl/plso_pkg.sv
package plso_pkg;
  localparam int BYTE_W = 8;

  // Per-slice asynchronous strobes, active low
  typedef struct packed {
    logic [BYTE_W-1:0] setN;
    logic [BYTE_W-1:0] clrN;
  } loadStrobe_t;
endpackage

// File: rtl/plsoCtrl.sv
module plsoCtrl
  import plso_pkg::*;
#(
  parameter int NUM_BYTES = 2,
  localparam int W = BYTE_W * NUM_BYTES
) (
  input  logic clk,
  input  logic clkEnN,
  input  logic loadN,
  input  logic [W-1:0] parIn,
  output logic effClk,
  output loadStrobe_t [NUM_BYTES-1:0] strb
);
  // Gated-OR clock: either pin may serve as the clock
  always_comb effClk = clk | clkEnN;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_strb
    logic [BYTE_W-1:0] dByte;
    assign dByte = parIn[b*BYTE_W +: BYTE_W];
    assign strb[b].setN = ~({BYTE_W{~loadN}} & dByte);
    assign strb[b].clrN = ~({BYTE_W{~loadN}} & ~dByte);
  end
endmodule

// File: rtl/plsoSlice.sv
module plsoSlice
  import plso_pkg::*;
(
  input  logic effClk,
  input  loadStrobe_t strb,
  input  logic serIn,
  output logic lastQ
);
  logic [BYTE_W-1:0] setN;
  logic [BYTE_W-1:0] clrN;
  logic [BYTE_W-1:0] q;
  logic [BYTE_W-1:0] nxt;

  assign setN = strb.setN;
  assign clrN = strb.clrN;
  assign nxt  = {q[BYTE_W-2:0], serIn};

  for (genvar i = 0; i < BYTE_W; i++) begin : g_stage
    logic stageQ;
    always_ff @(posedge effClk or negedge setN[i] or negedge clrN[i]) begin
      if (!clrN[i])      stageQ <= 1'b0;
      else if (!setN[i]) stageQ <= 1'b1;
      else               stageQ <= nxt[i];
    end
    assign q[i] = stageQ;
  end

  assign lastQ = q[BYTE_W-1];
endmodule

// File: rtl/plsoShiftReg.sv
module plsoShiftReg
  import plso_pkg::*;
#(
  parameter int NUM_BYTES = 2,
  localparam int W = BYTE_W * NUM_BYTES
) (
  input  logic clk,
  input  logic clkEnN,
  input  logic loadN,
  input  logic [W-1:0] parIn,
  input  logic serIn,
  output logic serOut,
  output logic serOutN
);
  logic effClk;
  loadStrobe_t [NUM_BYTES-1:0] strb;
  logic [NUM_BYTES:0] link;

  plsoCtrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk(clk), .clkEnN(clkEnN), .loadN(loadN), .parIn(parIn),
    .effClk(effClk), .strb(strb)
  );

  assign link[0] = serIn;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_slice
    plsoSlice u_slice (
      .effClk(effClk), .strb(strb[b]), .serIn(link[b]), .lastQ(link[b+1])
    );
  end

  assign serOut  = link[NUM_BYTES];
  assign serOutN = ~link[NUM_BYTES];
endmodule

// File: rtl/plsoShiftReg_chk.sv
module plsoShiftReg_chk (
  input logic clk,
  input logic clkEnN,
  input logic loadN,
  input logic parMsb,
  input logic serOut,
  input logic serOutN
);
  logic primed = 1'b0;
  always_ff @(negedge loadN) primed <= 1'b1;

  // R1: during load the last stage follows the top parallel bit
  p_load_follow_r1: assert property (@(posedge clk) disable iff (!primed)
    !loadN |-> serOut == parMsb);

  // R4: enable high across two edges with no load keeps the output
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!primed)
    (clkEnN && $past(clkEnN) && loadN && $past(loadN)) |-> $stable(serOut));

  // R5: complementary outputs
  p_comp_out_r5: assert property (@(posedge clk) disable iff (!primed)
    serOutN == !serOut);

  // R8: load release only while clock or enable is high
  p_release_safe_r8: assert property (@(posedge loadN) disable iff (!primed)
    clk || clkEnN);
endmodule

bind plsoShiftReg plsoShiftReg_chk u_chk (
  .clk(clk), .clkEnN(clkEnN), .loadN(loadN), .parMsb(parIn[W-1]),
  .serOut(serOut), .serOutN(serOutN)
);

// File: tb/plsoShiftReg_tb.sv
module plsoShiftReg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int W = 8 * NB;

  logic clk = 1'b0;
  logic clkRun = 1'b1;
  logic clkEnN = 1'b1;
  logic loadN = 1'b1;
  logic [W-1:0] parIn = '0;
  logic serIn = 1'b0;
  logic serOut, serOutN;
  logic [W-1:0] model;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  plsoShiftReg #(.NUM_BYTES(NB)) u_dut (
    .clk(clk), .clkEnN(clkEnN), .loadN(loadN), .parIn(parIn),
    .serIn(serIn), .serOut(serOut), .serOutN(serOutN)
  );

  always #(CLK_PERIOD/2) if (clkRun) clk = ~clk;

  task automatic check(string req, logic act, logic exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Shift n bits with the enable low, checking each bit as it emerges
  task automatic tShift(int n, logic [31:0] bits, string tag);
    @(posedge clk); #1 clkEnN = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); serIn = bits[i];
      @(posedge clk); model = {model[W-2:0], bits[i]};
      #1;
      if (i == n - 1) clkEnN = 1'b1;
      check((i >= W - 1) ? "R6" : tag, serOut, model[W-1], "shift out");
      check("R5", serOutN, ~model[W-1], "inverse out");
    end
  endtask

  task automatic tLoadLevel();
    #1 loadN = 1'b0; parIn = '0;
    #2 check("R1", serOut, 1'b0, "load zero");
    check("R5", serOutN, 1'b1, "load zero inverse");
    parIn = 16'h8001;
    #2 check("R1", serOut, 1'b1, "follow msb set");
    parIn = 16'h7FFE;
    #2 check("R1", serOut, 1'b0, "follow msb clear");
    check("R5", serOutN, 1'b1, "follow inverse");
    parIn = 16'hA5C3;
    #2 loadN = 1'b1;
    model = 16'hA5C3;
    #2 check("R8", serOut, 1'b1, "release with enable high");
    tShift(W, 32'h0, "R2");
  endtask

  task automatic tLoadClocked(logic [W-1:0] v);
    @(negedge clk); loadN = 1'b0; parIn = v;
    @(posedge clk); #1 clkEnN = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R7", serOut, v[W-1], "clock ignored in load");
    loadN = 1'b1;
    #1 check("R8", serOut, v[W-1], "release with clock high");
    clkEnN = 1'b1;
    model = v;
    tShift(W, 32'h0, "R7");
  endtask

  task automatic tCascade();
    @(negedge clk); loadN = 1'b0; parIn = 16'h0180;
    #2 loadN = 1'b1; model = 16'h0180;
    tShift(W + 8, 32'h00B4_0000 | 32'hB4 << 16, "R2");
  endtask

  task automatic tHold();
    @(negedge clk); loadN = 1'b0; parIn = 16'h3C96;
    #2 loadN = 1'b1; model = 16'h3C96;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); serIn = ~serIn;
      @(posedge clk); #1 check("R4", serOut, model[W-1], "hold output");
    end
    tShift(W, 32'hFFFF, "R4");
  endtask

  task automatic tSwap();
    @(negedge clk); loadN = 1'b0; parIn = 16'h5000;
    #2 loadN = 1'b1; model = 16'h5000;
    clkRun = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #3 clkEnN = 1'b0; serIn = i[0];
      #3 clkEnN = 1'b1;
      model = {model[W-2:0], i[0]};
      #2 check("R3", serOut, model[W-1], "enable as clock");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R2: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tLoadLevel();
    tLoadClocked(16'h8000);
    tLoadClocked(16'h0001);
    tLoadClocked(16'hAAAA);
    tCascade();
    tHold();
    tSwap();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule